// File: doc/BRIEF.md
# Folded Four-Lane Polar Encoder

This block encodes length-32 polar codewords as a stream. Every clock it accepts one 4-bit slice of the information vector and delivers one 4-bit slice of the codeword. A full codeword therefore occupies eight consecutive cycles at each side, and a new codeword may follow the previous one with no idle cycle between them. The stream runs at a sustained four bits per clock.

The five butterfly stages of the length-32 transform are folded onto four lanes. The first two stages pair bits that arrive in the same word, so they are plain XOR logic with no storage. The last three stages pair bits that lie 1, 2 and 4 words apart. Each of these stages holds operands in a short delay line, 4, 8 and 16 bits deep, which makes 28 storage bits in total. A per-stage select, driven by the word index of the operand leaving the line, decides whether the XOR partner is combined in. The codeword leaves in bit-reversed index order. Frozen-bit placement is the caller's job: frozen positions simply carry zero on the input.

Top module: `polar_fold_enc`

## Requirements
- R1: While reset is held, and after it is released until the first frame has gone through, `out_vld` and `out_sof` are low and `out_bits` is zero.
- R2: A frame is eight consecutive cycles with `in_vld` high, and `in_sof` marks the first of them. On the w-th word of the frame (w = 0 on the `in_sof` word), `in_bits[k]` carries information bit u[4w+k].
- R3: Output word t of a frame (t = 0 on the `out_sof` word) carries in lane k the bit y[4t+k], where y[j] is the XOR of every u[i] whose index satisfies (i AND j) == j. This is codeword bit x[bitrev5(4t+k)] of the standard polar code with bit-reversal permutation.
- R4: Each input frame produces exactly eight consecutive cycles with `out_vld` high. `out_sof` is high on the first of them only.
- R5: `out_sof` rises exactly 7 cycles after the clock edge that captured `in_sof`, and every later word of the frame follows with the same delay.
- R6: Frames given back to back, with no idle cycle between them, come out back to back and are each encoded correctly.
- R7: Idle gaps of any length may separate frames. While `in_vld` is low, `in_bits` and `in_sof` are ignored and do not affect any later codeword.
- R8: A unit input (u[i] = 1, all other bits 0) yields ones exactly at the output positions j whose set bits are a subset of the set bits of i.
- R9: An all-ones input yields a single one at y[31]. That is the last output word equal to 4'b1000, with every other word zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame (qualified by `in_vld`) |
| in_bits | input | LANES (4) | Four information bits, lane k is index 4w+k |
| out_vld | output | 1 | Output word valid |
| out_sof | output | 1 | First word of an output codeword |
| out_bits | output | LANES (4) | Four code bits in bit-reversed order |

## Verification
Each input word passes through delay lines of 1, 2 and 4 cycles. The output register takes it in the same cycle that the last line releases it, so every result is due exactly 7 clock edges after the edge that captured its input word. The bench records the cycle number at which each `in_sof` is captured. It then requires the matching `out_sof` to be seen, at the falling edge, 7 cycles later. A frame is compared only after eight contiguous valid output words have been gathered, so a gap, a missing start marker or an early marker is reported as a framing error rather than silently misaligning the comparison. Expected codewords come from a direct subset-parity sum, which shares nothing with the folded butterfly structure.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int unsigned PF_CODE_LEN = 32;
  localparam int unsigned PF_LANES    = 4;

  // ceiling log2, used to size index fields and stage counts
  function automatic int unsigned lg2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/pf_intra_word.sv
// Butterfly stages whose operands share one input word: pure XOR logic.
module pf_intra_word #(
  parameter int unsigned LANES = pf_pkg::PF_LANES
) (
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);
  localparam int unsigned LOGP = pf_pkg::lg2(LANES);

  logic [LANES-1:0] lvl [LOGP+1];

  assign lvl[0] = din;

  for (genvar s = 0; s < LOGP; s++) begin : g_lvl
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (((i >> s) & 1) == 0) begin : g_top
        localparam int unsigned PARTNER = i + (1 << s);
        assign lvl[s+1][i] = lvl[s][i] ^ lvl[s][PARTNER];
      end else begin : g_pass
        assign lvl[s+1][i] = lvl[s][i];
      end
    end
  end

  assign dout = lvl[LOGP];

  // R3: after all in-word stages lane 0 holds the parity of the whole word
  always_comb begin
    a_r3_lane0_parity: assert (lvl[LOGP][0] == ^din)
      else $error("lane 0 is not the parity of the input word");
  end

endmodule

// File: rtl/pf_frame_ctrl.sv
// Tracks the word index of the incoming word within its frame.
module pf_frame_ctrl #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned TAGW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic            in_sof,
  output logic [TAGW-1:0] idx
);
  logic [TAGW-1:0] cnt_q, cnt_d;
  logic            start;
  logic            cnt_en;

  always_comb begin
    start  = in_vld & in_sof;
    idx    = start ? '0 : cnt_q;
    cnt_en = in_vld;
    cnt_d  = idx + TAGW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: a frame is delivered as eight uninterrupted valid words
  a_r2_frame_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_vld) && ($past(idx) != TAGW'(WORDS-1))) |-> in_vld)
    else $error("input frame interrupted before its last word");

endmodule

// File: rtl/pf_fold_stage.sv
// One folded butterfly stage pairing words DIST apart: a DIST-word delay
// line plus a partner select driven by the index of the departing word.
module pf_fold_stage #(
  parameter int unsigned LANES = pf_pkg::PF_LANES,
  parameter int unsigned DIST  = 1,
  parameter int unsigned TAGW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  input  logic             din_vld,
  input  logic [TAGW-1:0]  din_idx,
  output logic [LANES-1:0] dout,
  output logic             dout_vld,
  output logic [TAGW-1:0]  dout_idx
);
  localparam int unsigned SEL = pf_pkg::lg2(DIST);

  logic [LANES-1:0] dat_q [DIST];
  logic [LANES-1:0] dat_d [DIST];
  logic             vld_q [DIST];
  logic             vld_d [DIST];
  logic [TAGW-1:0]  idx_q [DIST];
  logic [TAGW-1:0]  idx_d [DIST];
  logic             take_partner;

  always_comb begin
    dat_d[0] = din;
    vld_d[0] = din_vld;
    idx_d[0] = din_idx;
    for (int k = 1; k < DIST; k++) begin
      dat_d[k] = dat_q[k-1];
      vld_d[k] = vld_q[k-1];
      idx_d[k] = idx_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DIST; k++) begin
        dat_q[k] <= '0;
        vld_q[k] <= 1'b0;
        idx_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < DIST; k++) begin
        dat_q[k] <= dat_d[k];
        vld_q[k] <= vld_d[k];
        idx_q[k] <= idx_d[k];
      end
    end
  end

  always_comb begin
    dout_vld     = vld_q[DIST-1];
    dout_idx     = idx_q[DIST-1];
    take_partner = ~dout_idx[SEL];
    dout         = dat_q[DIST-1] ^ (take_partner ? din : '0);
  end

  // R3: an upper operand leaves only while its partner sits on the input
  a_r3_partner_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && !dout_idx[SEL]) |-> (din_vld && (din_idx == dout_idx + TAGW'(DIST))))
    else $error("butterfly partner not aligned");

endmodule

// File: rtl/polar_fold_enc.sv
module polar_fold_enc #(
  parameter int unsigned CODE_LEN = pf_pkg::PF_CODE_LEN,
  parameter int unsigned LANES    = pf_pkg::PF_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_sof,
  input  logic [LANES-1:0] in_bits,
  output logic             out_vld,
  output logic             out_sof,
  output logic [LANES-1:0] out_bits
);
  localparam int unsigned WORDS = CODE_LEN / LANES;
  localparam int unsigned LOGW  = pf_pkg::lg2(WORDS);
  localparam int unsigned TAGW  = (LOGW == 0) ? 1 : LOGW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [TAGW-1:0]  idx;
  logic [LANES-1:0] mixed;

  pf_frame_ctrl #(.WORDS(WORDS), .TAGW(TAGW)) u_ctrl (
    .clk    (clk),
    .rst_n  (srst_n),
    .in_vld (in_vld),
    .in_sof (in_sof),
    .idx    (idx)
  );

  pf_intra_word #(.LANES(LANES)) u_intra (
    .din  (in_bits),
    .dout (mixed)
  );

  logic [LANES-1:0] s_dat [LOGW+1];
  logic             s_vld [LOGW+1];
  logic [TAGW-1:0]  s_idx [LOGW+1];

  assign s_dat[0] = mixed;
  assign s_vld[0] = in_vld;
  assign s_idx[0] = idx;

  for (genvar g = 0; g < LOGW; g++) begin : g_fold
    pf_fold_stage #(.LANES(LANES), .DIST(1 << g), .TAGW(TAGW)) u_stage (
      .clk      (clk),
      .rst_n    (srst_n),
      .din      (s_dat[g]),
      .din_vld  (s_vld[g]),
      .din_idx  (s_idx[g]),
      .dout     (s_dat[g+1]),
      .dout_vld (s_vld[g+1]),
      .dout_idx (s_idx[g+1])
    );
  end

  // output register
  logic             vld_nxt;
  logic             sof_nxt;
  logic             bits_en;

  always_comb begin
    vld_nxt = s_vld[LOGW];
    sof_nxt = s_vld[LOGW] && (s_idx[LOGW] == '0);
    bits_en = s_vld[LOGW];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_vld  <= 1'b0;
      out_sof  <= 1'b0;
      out_bits <= '0;
    end else begin
      out_vld <= vld_nxt;
      out_sof <= sof_nxt;
      if (bits_en) out_bits <= s_dat[LOGW];
    end
  end

  // R4: a non-first output word always continues a running frame
  a_r4_words_contiguous: assert property (@(posedge clk) disable iff (!srst_n)
    (out_vld && !out_sof) |-> $past(out_vld))
    else $error("output word without a preceding word of its frame");

endmodule

// File: tb/test_polar_fold_enc.sv
module test_polar_fold_enc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic       in_sof = 1'b0;
  logic [3:0] in_bits = 4'h0;
  logic       out_vld;
  logic       out_sof;
  logic [3:0] out_bits;

  polar_fold_enc i_polar_fold_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_sof   (in_sof),
    .in_bits  (in_bits),
    .out_vld  (out_vld),
    .out_sof  (out_sof),
    .out_bits (out_bits)
  );

  always #5 clk = ~clk;

  localparam int LAT = 7;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  int frames_in = 0;
  int frames_out = 0;
  int words_out = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          cap_q [$];

  bit          collecting = 1'b0;
  int          widx = 0;
  logic [31:0] got = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // y[j] = XOR of u[i] over every i whose bits contain those of j
  function automatic logic [31:0] enc_model(input logic [31:0] u);
    logic [31:0] y;
    for (int j = 0; j < 32; j++) begin
      y[j] = 1'b0;
      for (int i = 0; i < 32; i++)
        if ((i & j) == j) y[j] = y[j] ^ u[i];
    end
    return y;
  endfunction

  task automatic send_frame(input logic [31:0] u, input string req);
    exp_q.push_back(enc_model(u));
    tag_q.push_back(req);
    frames_in++;
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      in_vld  = 1'b1;
      in_sof  = (w == 0);
      in_bits = u[4*w +: 4];
      if (w == 0) cap_q.push_back(cyc + 1);
    end
  endtask

  task automatic idle(input int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      in_vld  = 1'b0;
      in_sof  = 1'($urandom);
      in_bits = 4'($urandom);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        words_out++;
        if (out_sof) begin
          if (collecting) chk(1'b0, "R4 R6 early start marker", 32'(widx), 32'd8);
          collecting = 1'b1;
          widx = 0;
          got = '0;
          if (cap_q.size() == 0) chk(1'b0, "R5 unexpected frame", 32'(cyc), 32'd0);
          else begin
            int cap;
            cap = cap_q.pop_front();
            chk((cyc - cap) == LAT, "R5 latency", 32'(cyc - cap), 32'(LAT));
          end
        end else if (!collecting) begin
          chk(1'b0, "R4 word without start marker", 32'(out_bits), 32'd0);
        end
        if (collecting) begin
          got[4*widx +: 4] = out_bits;
          widx++;
          if (widx == 8) begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = tag_q.pop_front();
            chk(got == e, r, got, e);
            collecting = 1'b0;
            frames_out++;
          end
        end
      end else if (collecting) begin
        chk(1'b0, "R4 gap inside output frame", 32'(widx), 32'd8);
        collecting = 1'b0;
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired (frames in=%0d out=%0d)", frames_in, frames_out);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    int gap;
    logic [31:0] u;
    seed = $urandom(32'h1d5e_a7c3);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld in reset", 32'(out_vld), 32'd0);
    chk(out_sof == 1'b0, "R1 out_sof in reset", 32'(out_sof), 32'd0);
    chk(out_bits == 4'h0, "R1 out_bits in reset", 32'(out_bits), 32'd0);
    rst_n = 1'b1;
    idle(6);
    chk(out_vld == 1'b0, "R1 out_vld after release", 32'(out_vld), 32'd0);
    chk(out_bits == 4'h0, "R1 out_bits after release", 32'(out_bits), 32'd0);

    // directed corner cases
    send_frame(32'hFFFF_FFFF, "R9 R3 all ones");
    chk(enc_model(32'hFFFF_FFFF) == 32'h8000_0000, "R9 expected single one", enc_model(32'hFFFF_FFFF), 32'h8000_0000);
    send_frame(32'h0000_0000, "R3 all zeros");
    idle(3);
    send_frame(32'h0000_0001, "R8 unit index 0");
    send_frame(32'h0000_0002, "R8 unit index 1");
    send_frame(32'h0000_0020, "R8 unit index 5");
    send_frame(32'h0001_0000, "R8 unit index 16");
    send_frame(32'h8000_0000, "R8 unit index 31");
    idle(9);
    send_frame(32'h0000_000F, "R2 R3 lanes of word 0");
    send_frame(32'hF000_0000, "R2 R3 lanes of word 7");

    // random frames with random gaps (zero gap gives back-to-back frames)
    for (int f = 0; f < 150; f++) begin
      gap = int'($urandom % 4);
      if (gap == 0) begin
        u = $urandom;
        send_frame(u, "R2 R3 R6 back-to-back");
      end else begin
        idle(gap);
        u = $urandom;
        send_frame(u, "R2 R3 R7 after idle gap");
      end
    end

    idle(20);
    chk(frames_out == frames_in, "R6 R7 frame count", 32'(frames_out), 32'(frames_in));
    chk(words_out == 8 * frames_in, "R4 output word count", 32'(words_out), 32'(8 * frames_in));
    chk(exp_q.size() == 0, "R4 frames left unseen", 32'(exp_q.size()), 32'd0);
    chk(out_vld == 1'b0, "R7 quiet while idle", 32'(out_vld), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule